// File: doc/BRIEF.md
# Management Data Frame Master

This block is the master side of a two-wire PHY management bus. It divides the system clock down to a management clock (MDC). It shifts a complete frame out on the bidirectional data line (MDIO). For read frames it releases the line and shifts the PHY's answer back in. Both the legacy register frame format (Clause 22) and the extended, indirect-address format (Clause 45) are produced. A mode bit decides how the two-bit operation code is interpreted.

Software drives four word registers through a simple write strobe and a combinational read mux:

- A configuration word holds the clause mode, a preamble enable and a clock divider.
- A write-data word holds the 16-bit value to send. In an extended address frame, this value is the register address.
- A command word holds the operation code, the PHY address and the register/device field. Writing it starts exactly one frame.
- A read-data word returns the captured 16 bits.

Completion is visible as pending flags. A pending flag sits in the write-data word for address and write frames, and in the read-data word for read frames. The read-data word also has a valid flag that software must see set before it trusts the data. An extended access is done in two steps. Software first issues an address frame, then a write or read frame to the same device.

Top module: `mgmt_frame_master`

## Requirements
- R1: Configuration bit 0 selects the frame format.
  - With bit 0 = 0 (Clause 22), the frame starts with start bits 01. The opcode bits are 01 for op 0 (write) and 10 for op 1 (read).
  - With bit 0 = 1 (Clause 45), the frame starts with start bits 00. The opcode bits are 00 for op 0 (address), 01 for op 1 (write) and 11 for op 3 (read).
  - All fields are sent MSB first.
- R2: When configuration bit 1 is set, each frame begins with 32 ones. When it is clear, no preamble is sent.
- R3: The command word carries the op in bits [1:0], the PHY address in bits [12:8] and the register/device field in bits [20:16]. The PHY address and then the register/device field follow the opcode bits on the line. Writing the command word launches one frame, and the command reads back at the same address.
- R4: MDC has a period of 2*(div+1) system clocks, where div is configuration bits [15:8].
  - Each bit starts with the low half. MDC idles low between frames.
  - MDIO changes only at a falling edge of MDC or at frame launch.
- R5: Address and write frames drive MDIO for the whole frame. The frame ends with turnaround 10, followed by bits [15:0] of the write-data word.
- R6: Read frames release MDIO (output enable low) for the 2 turnaround bits and the 16 data bits. MDIO is sampled on each rising MDC edge of the data bits, MSB first, into read-data bits [15:0].
- R7: Write-data bit 31 is 1 from the launch of an address or write frame until that frame has ended. Read-data bit 31 is 1 over the same span for a read frame.
- R8: Read-data bit 30 (valid) clears when a read frame launches. It sets at the rising MDC edge that captures the 16th data bit.
- R9: A command write while a frame is pending is ignored. No second frame follows.
- R10: An op code undefined in the current mode is ignored and launches nothing. The undefined codes are 2 or 3 in Clause 22 and 2 in Clause 45.
- R11: After reset, MDC and the output enable are low, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write select: 0 config, 1 command, 2 write data, 3 read data (read-only) |
| wr_data | input | 32 | Register write value |
| rd_addr | input | 2 | Read select, same encoding as wr_addr |
| rd_data | output | 32 | Selected register contents (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the pad |

## Verification
The assertions assume the divider stays constant for the whole of a frame. The design ensures this by taking a copy at launch. They also assume software issues at most one register access per cycle, which the single write port enforces. The bench changes the configuration only between frames, and it deliberately issues command writes in the middle of a frame and with undefined op codes. Its responder drives mdio_i only during released data bits and otherwise leaves the line pulled high. As a result, the captured value depends only on the sample instants.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam logic [1:0] SEL_CFG  = 2'd0;
  localparam logic [1:0] SEL_CMD  = 2'd1;
  localparam logic [1:0] SEL_WDAT = 2'd2;
  localparam logic [1:0] SEL_RDAT = 2'd3;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;

  typedef struct packed {
    logic [4:0] dev;
    logic [4:0] phy;
    logic [1:0] op;
  } cmd_t;

  // op codes that start a frame in the selected mode
  function automatic logic op_legal(input logic c45, input logic [1:0] op);
    return c45 ? (op != 2'd2) : (op[1] == 1'b0);
  endfunction

  function automatic logic op_is_read(input logic c45, input logic [1:0] op);
    return c45 ? (op == 2'd3) : (op == 2'd1);
  endfunction

  // start bits followed by line opcode bits
  function automatic logic [3:0] st_op_bits(input logic c45, input logic [1:0] op);
    if (c45) return {2'b00, op};
    return {2'b01, (op == 2'd1) ? 2'b10 : 2'b01};
  endfunction

  function automatic logic [FRAME_W-1:0] build_frame(input logic c45, input cmd_t c,
                                                     input logic [DATA_W-1:0] wd);
    return {st_op_bits(c45, c.op), c.phy, c.dev, 2'b10, wd};
  endfunction
endpackage

// File: rtl/mgmt_clk_div.sv
module mgmt_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             half_end
);
  logic [DIV_W-1:0] cnt;

  assign half_end = run && (cnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!run || cnt == div) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  // R4: the half-period counter never passes the latched divider
  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt <= div);
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               launch,
  input  logic [FRAME_W-1:0] frame,
  input  logic               pre_en,
  input  logic               is_read,
  input  logic               half_end,
  input  logic               mdio_i,
  output logic               busy,
  output logic               mdc,
  output logic               mdio_o,
  output logic               mdio_oe,
  output logic [DATA_W-1:0]  rdat,
  output logic               rise_evt,
  output logic               fall_evt,
  output logic               cap_done
);
  localparam logic [5:0] PRE_LEN  = 6'd32;
  localparam logic [6:0] LAST_IDX = 7'(FRAME_W - 1);
  localparam logic [6:0] DRV_RD   = 7'(FRAME_W - DATA_W - 2);
  localparam logic [6:0] DAT_IDX  = 7'(FRAME_W - DATA_W);

  logic [6:0]         bidx;
  logic [5:0]         pre_len;
  logic [FRAME_W-1:0] shreg;
  logic               rd_q;
  logic               in_pre, last_bit, cap_bit;
  logic [6:0]         fidx;

  assign in_pre   = bidx < {1'b0, pre_len};
  assign fidx     = bidx - {1'b0, pre_len};
  assign last_bit = !in_pre && (fidx == LAST_IDX);
  assign rise_evt = busy && half_end && !mdc;
  assign fall_evt = busy && half_end && mdc;
  assign cap_bit  = rise_evt && rd_q && !in_pre && (fidx >= DAT_IDX);
  assign cap_done = cap_bit && last_bit;
  assign mdio_o   = busy && (in_pre || shreg[FRAME_W-1]);
  assign mdio_oe  = busy && (in_pre || !rd_q || fidx < DRV_RD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      mdc     <= 1'b0;
      bidx    <= '0;
      pre_len <= '0;
      shreg   <= '0;
      rd_q    <= 1'b0;
      rdat    <= '0;
    end else if (launch) begin
      busy    <= 1'b1;
      mdc     <= 1'b0;
      bidx    <= '0;
      pre_len <= pre_en ? PRE_LEN : 6'd0;
      shreg   <= frame;
      rd_q    <= is_read;
    end else if (rise_evt) begin
      mdc <= 1'b1;
      if (cap_bit) rdat <= {rdat[DATA_W-2:0], mdio_i};
    end else if (fall_evt) begin
      mdc <= 1'b0;
      if (last_bit) busy <= 1'b0;
      else          bidx <= bidx + 1'b1;
      if (!in_pre) shreg <= shreg << 1;
    end
  end

  // R4: clock parks low outside a frame
  assert_mdc_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R4: line value moves only after a falling clock edge inside a frame
  assert_mdio_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $past(fall_evt));
  // R6: every sample is taken with the line released
  assert_sample_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_bit |-> !mdio_oe);
endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
  import mgmt_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic               cfg_c45, cfg_pre;
  logic [DIV_W-1:0]   cfg_div, div_run;
  cmd_t               cmd_q, cmd_in;
  logic [DATA_W-1:0]  wdat, rdat;
  logic               rd_valid, cur_rd;
  logic               busy, half_end, rise_evt, fall_evt, cap_done;
  logic               cmd_wr, launch, launch_rd;
  logic [FRAME_W-1:0] frame;
  logic               unused_wr_bits;

  assign unused_wr_bits = ^{wr_data[31:21], wr_data[7:2]};
  assign cmd_in    = '{dev: wr_data[20:16], phy: wr_data[12:8], op: wr_data[1:0]};
  assign cmd_wr    = wr_en && (wr_addr == SEL_CMD);
  assign launch    = cmd_wr && !busy && op_legal(cfg_c45, cmd_in.op);
  assign launch_rd = op_is_read(cfg_c45, cmd_in.op);
  assign frame     = build_frame(cfg_c45, cmd_in, wdat);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_c45  <= 1'b0;
      cfg_pre  <= 1'b0;
      cfg_div  <= '0;
      div_run  <= '0;
      cmd_q    <= '0;
      wdat     <= '0;
      rd_valid <= 1'b0;
      cur_rd   <= 1'b0;
    end else begin
      if (wr_en && wr_addr == SEL_CFG) begin
        cfg_c45 <= wr_data[0];
        cfg_pre <= wr_data[1];
        cfg_div <= wr_data[8 +: DIV_W];
      end
      if (wr_en && wr_addr == SEL_WDAT) wdat <= wr_data[DATA_W-1:0];
      if (launch) begin
        cmd_q   <= cmd_in;
        div_run <= cfg_div;
        cur_rd  <= launch_rd;
      end
      if (launch && launch_rd) rd_valid <= 1'b0;
      else if (cap_done)       rd_valid <= 1'b1;
    end
  end

  mgmt_clk_div #(.DIV_W(DIV_W)) clk_div_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div_run), .half_end(half_end)
  );

  mgmt_frame_engine engine_i (
    .clk(clk), .rst_n(rst_n), .launch(launch), .frame(frame), .pre_en(cfg_pre),
    .is_read(launch_rd), .half_end(half_end), .mdio_i(mdio_i), .busy(busy),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdat(rdat),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .cap_done(cap_done)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      SEL_CFG: begin
        rd_data[0]          = cfg_c45;
        rd_data[1]          = cfg_pre;
        rd_data[8 +: DIV_W] = cfg_div;
      end
      SEL_CMD:  rd_data = {11'd0, cmd_q.dev, 3'd0, cmd_q.phy, 6'd0, cmd_q.op};
      SEL_WDAT: rd_data = {busy && !cur_rd, 15'd0, wdat};
      default:  rd_data = {busy && cur_rd, rd_valid, 14'd0, rdat};
    endcase
  end

  // R9: a command arriving mid-frame leaves the latched command alone
  assert_cmd_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |=> $stable(cmd_q));
  // R8: valid only rises on the capture of the final data bit
  assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |-> $past(cap_done));
  // R8: a read launch withdraws valid
  assert_valid_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && launch_rd) |=> !rd_valid);
  // R10: undefined op codes start nothing
  assert_bad_op_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !busy && !op_legal(cfg_c45, cmd_in.op)) |=> !busy);
endmodule

// File: tb/mgmt_frame_master_tb_top.sv
`timescale 1ns/1ps
module mgmt_frame_master_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, mdio_i = 1'b1;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data, rv;
  logic        mdc, mdio_o, mdio_oe;

  int n_chk = 0, n_fail = 0, rise_cnt = 0, r0;
  bit done_flag = 0;

  // behavioural reference state
  bit        m_act = 0, m_read = 0, m_valid = 0, m_c45 = 0, m_pre = 0;
  int        m_t = 0, m_h = 1, m_n = 0, m_drive = 0, m_div = 0;
  logic [15:0] m_wd = '0, m_resp = '0;
  bit        mq[$];

  always #4 clk = ~clk;

  mgmt_frame_master dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic void push_bits(input int v, input int w);
    for (int i = w - 1; i >= 0; i--) mq.push_back(v[i]);
  endfunction

  function automatic bit tb_ok_op(input bit c45, input int op);
    if (c45) return op == 0 || op == 1 || op == 3;
    return op == 0 || op == 1;
  endfunction

  always @(posedge mdc) if (rst_n) rise_cnt++;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_valid = 0; m_c45 = 0; m_pre = 0; m_div = 0; m_wd = '0;
    end else begin
      if (m_act) begin
        m_t++;
        if (m_read && m_t == 2*m_h*(m_n-1) + m_h) m_valid = 1;
        if (m_t == 2*m_h*m_n) m_act = 0;
      end else if (wr_en && wr_addr == 2'd1 && tb_ok_op(m_c45, int'(wr_data[1:0]))) begin
        int op;
        op = int'(wr_data[1:0]);
        m_read = m_c45 ? (op == 3) : (op == 1);
        mq.delete();
        if (m_pre) push_bits(-1, 32);
        push_bits(m_c45 ? 0 : 1, 2);
        push_bits(m_c45 ? op : (m_read ? 2 : 1), 2);
        push_bits(int'(wr_data[12:8]), 5);
        push_bits(int'(wr_data[20:16]), 5);
        push_bits(2, 2);
        push_bits(int'(m_wd), 16);
        m_n = mq.size();
        m_drive = m_read ? m_n - 18 : m_n;
        m_h = m_div + 1;
        m_t = 0;
        m_act = 1;
        if (m_read) m_valid = 0;
      end
      if (wr_en && wr_addr == 2'd0) begin
        m_c45 = wr_data[0]; m_pre = wr_data[1]; m_div = int'(wr_data[15:8]);
      end
      if (wr_en && wr_addr == 2'd2) m_wd = wr_data[15:0];
    end
  end

  // per-cycle comparison against the reference, then responder drive
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      int idx, fi;
      bit e_mdc, e_oe;
      string tag;
      idx   = m_t / (2*m_h);
      e_mdc = m_act && ((m_t % (2*m_h)) >= m_h);
      e_oe  = m_act && idx < m_drive;
      chk(mdc == e_mdc, "R4", 32'(mdc), 32'(e_mdc));
      chk(mdio_oe == e_oe, m_read ? "R6" : "R5", 32'(mdio_oe), 32'(e_oe));
      if (e_oe) begin
        fi  = idx - (m_n - 32);
        tag = (fi < 0) ? "R2" : (fi < 4) ? "R1" : (fi < 14) ? "R3" : "R5";
        chk(mdio_o == mq[idx], tag, 32'(mdio_o), 32'(mq[idx]));
      end
      if (rd_addr == 2'd2) chk(rd_data[31] == (m_act && !m_read), "R7", 32'(rd_data[31]), 32'(m_act && !m_read));
      if (rd_addr == 2'd3) begin
        chk(rd_data[31] == (m_act && m_read), "R7", 32'(rd_data[31]), 32'(m_act && m_read));
        chk(rd_data[30] == m_valid, "R8", 32'(rd_data[30]), 32'(m_valid));
      end
      mdio_i = (m_act && m_read && idx >= m_n - 16) ? m_resp[m_n-1-idx] : 1'b1;
    end
  end

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a; #1; v = rd_data;
  endtask

  task automatic wait_idle();
    while (m_act) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] cmdw(input int op, input int phy, input int dev);
    return (32'(dev) << 16) | (32'(phy) << 8) | 32'(op);
  endfunction

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_fail++;
      $display("FAIL R4 watchdog act=%h exp=%h", 32'(0), 32'(1));
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(mdc == 0 && mdio_oe == 0, "R11", {mdc, mdio_oe}, 0);
    for (int a = 0; a < 4; a++) begin
      reg_rd(2'(a), rv); chk(rv == 0, "R11", rv, 0);
    end
    @(negedge clk);

    // Clause 22 write with preamble, divider 1
    reg_wr(0, 32'h0000_0102);
    reg_wr(2, 32'h0000_A5C3);
    rd_addr = 2'd2;
    r0 = rise_cnt;
    reg_wr(1, cmdw(0, 5, 3));
    reg_rd(2, rv); chk(rv[31] == 1, "R7", rv, 32'h8000_A5C3);
    @(negedge clk);
    wait_idle();
    reg_rd(2, rv); chk(rv == 32'h0000_A5C3, "R7", rv, 32'h0000_A5C3);
    chk(rise_cnt - r0 == 64, "R2", rise_cnt - r0, 64);
    reg_rd(1, rv); chk(rv == cmdw(0, 5, 3), "R3", rv, cmdw(0, 5, 3));
    @(negedge clk);

    // Clause 22 read, no preamble, divider 0
    reg_wr(0, 32'h0000_0000);
    m_resp = 16'h1234;
    rd_addr = 2'd3;
    r0 = rise_cnt;
    reg_wr(1, cmdw(1, 9, 17));
    reg_rd(3, rv); chk(rv[31:30] == 2'b10, "R8", rv, 32'h8000_0000);
    @(negedge clk);
    wait_idle();
    reg_rd(3, rv); chk(rv == 32'h4000_1234, "R6", rv, 32'h4000_1234);
    chk(rise_cnt - r0 == 32, "R2", rise_cnt - r0, 32);
    @(negedge clk);

    // R9: second command during a frame
    reg_wr(2, 32'h0000_00FF);
    rd_addr = 2'd2;
    reg_wr(1, cmdw(0, 1, 2));
    repeat (5) @(negedge clk);
    reg_wr(1, cmdw(0, 30, 31));
    wait_idle();
    r0 = rise_cnt;
    repeat (20) @(negedge clk);
    chk(rise_cnt == r0, "R9", rise_cnt - r0, 0);
    reg_rd(1, rv); chk(rv == cmdw(0, 1, 2), "R9", rv, cmdw(0, 1, 2));
    @(negedge clk);

    // Clause 45: address, write, read with preamble, divider 2
    reg_wr(0, 32'h0000_0203);
    reg_wr(2, 32'h0000_BEEF);
    reg_wr(1, cmdw(0, 4, 7));
    wait_idle();
    reg_wr(2, 32'h0000_0F0F);
    reg_wr(1, cmdw(1, 4, 7));
    wait_idle();
    reg_rd(2, rv); chk(rv == 32'h0000_0F0F, "R5", rv, 32'h0000_0F0F);
    @(negedge clk);
    m_resp = 16'h8001;
    rd_addr = 2'd3;
    reg_wr(1, cmdw(3, 4, 7));
    reg_rd(3, rv); chk(rv[30] == 0, "R8", rv, 32'h8000_0000);
    @(negedge clk);
    wait_idle();
    reg_rd(3, rv); chk(rv == 32'h4000_8001, "R6", rv, 32'h4000_8001);
    @(negedge clk);

    // R10: undefined op codes in both modes
    r0 = rise_cnt;
    reg_wr(1, cmdw(2, 3, 3));
    reg_rd(2, rv); chk(rv[31] == 0, "R10", rv, 32'h0);
    reg_rd(3, rv); chk(rv[31] == 0, "R10", rv, 32'h0);
    @(negedge clk);
    reg_wr(0, 32'h0000_0000);
    reg_wr(1, cmdw(3, 3, 3));
    reg_wr(1, cmdw(2, 3, 3));
    repeat (10) @(negedge clk);
    chk(rise_cnt == r0, "R10", rise_cnt - r0, 0);
    reg_rd(3, rv); chk(rv == 32'h4000_8001, "R10", rv, 32'h4000_8001);

    done_flag = 1;
    summary();
    $finish;
  end
endmodule